// File: doc/BRIEF.md
# Oscillator Lock Health Sequencer

This block turns the acquisition progress of a frequency-locked oscillator into two clean control signals. An acquisition controller reports a phase code that starts at a fixed warm-up value and steps down to zero once the loop is locked. The sequencer registers that code and publishes it. It also drives a registered health flag, where 1 means not healthy. The flag is forced to 1 at reset and whenever the phase code is non-zero.

Reaching code zero is not enough to report health. The loop must first stay at zero for a qualification interval, counted on a one-second tick. Only after that interval does the flag fall and a `locked` qualifier rise, which other blocks use to gate their actions. Once the block is qualified, a lock-fail or alarm input raises the flag on the very next clock. The full interval then has to be served again before health is reported.

Top module: `lock_health_seq`

## Requirements
- R1: A synchronous active-high reset sets `phase_o` to the start code 8 (warm-up), `unhealthy_o` to 1 and `locked_o` to 0.
- R2: `phase_o` shows the value of `phase_code_i` sampled on the previous rising clock edge, so a descending sequence 8, 7, ... 0 appears one cycle later.
- R3: While `phase_o` is non-zero, the next clock edge leaves `unhealthy_o` at 1 and `locked_o` at 0, whatever `sec_tick_i` does.
- R4: From the first cycle where `phase_o` is 0, `unhealthy_o` stays 1 until 5 `sec_tick_i` pulses have been sampled with `phase_o` at 0 and `fault_i` low. It falls to 0 on the clock edge that samples the fifth pulse.
- R5: If `phase_o` becomes non-zero before the fifth pulse, the tick count goes back to zero, and a new run of 5 pulses is needed once the code is back at 0.
- R6: When `fault_i` is high while the block is qualified, `unhealthy_o` is 1 and `locked_o` is 0 after the next clock edge. After the fault clears, 5 new pulses are needed to qualify again.
- R7: `locked_o` is 1 exactly when `unhealthy_o` is 0. Extra ticks after qualification keep both outputs steady.
- R8: Ticks sampled while `fault_i` is high do not count toward the qualification interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_code_i | input | 4 | Acquisition phase code from the controller; 0 means locked |
| sec_tick_i | input | 1 | One-cycle pulse once per second |
| fault_i | input | 1 | Lock failure or alarm |
| phase_o | output | 4 | Registered phase code |
| unhealthy_o | output | 1 | Registered health flag, 1 = not healthy |
| locked_o | output | 1 | Registered qualified-lock indication |

## Verification
The hardest case to reach from the ports is a qualification interval that is interrupted partway and then restarted. The bench drives the code to zero and gives three ticks. It then brings back a non-zero code for one cycle and returns to zero. Four further ticks must leave the flag high, and the fifth must drop it. A similar pattern holds the fault input high through several ticks, then shows that a full run of five clean ticks is still needed afterwards.

// File: rtl/lock_seq_pkg.sv
package lock_seq_pkg;

    // Qualification progress of the lock sequencer
    typedef enum logic [1:0] {
        PH_ACQUIRE = 2'd0,
        PH_HOLD    = 2'd1,
        PH_QUAL    = 2'd2
    } qual_phase_e;

    // Registered indication pair presented at the block edge
    typedef struct packed {
        logic unhealthy;
        logic locked;
    } health_flags_t;

    function automatic health_flags_t flags_for(input qual_phase_e ph);
        health_flags_t f;
        f.unhealthy = (ph != PH_QUAL);
        f.locked    = (ph == PH_QUAL);
        return f;
    endfunction

endpackage

// File: rtl/lsq_phase_reg.sv
module lsq_phase_reg #(
    parameter int CODE_W     = 4,
    parameter int START_CODE = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code_i,
    output logic [CODE_W-1:0] phase_o
);
    localparam logic [CODE_W-1:0] START_V = CODE_W'(START_CODE);

    logic [CODE_W-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst) phase_q <= START_V;
        else     phase_q <= code_i;
    end

    assign phase_o = phase_q;

    // R1
    reset_code_chk: assert property (@(posedge clk) rst |=> phase_q == START_V);

    // R2
    follow_code_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> phase_q == $past(code_i));

endmodule

// File: rtl/lsq_hold_timer.sv
module lsq_hold_timer
    import lock_seq_pkg::*;
#(
    parameter int CODE_W    = 4,
    parameter int HOLD_SECS = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] phase_i,
    input  logic              tick_i,
    input  logic              fault_i,
    output qual_phase_e       next_phase_o
);
    localparam int CNT_W = $clog2(HOLD_SECS + 1);
    localparam logic [CNT_W-1:0] HOLD_V = CNT_W'(HOLD_SECS);

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             restart;

    assign restart = (phase_i != '0) || fault_i;

    always_comb begin
        cnt_d = cnt_q;
        if (restart)
            cnt_d = '0;
        else if (tick_i && (cnt_q != HOLD_V))
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    always_comb begin
        if (cnt_d == HOLD_V)    next_phase_o = PH_QUAL;
        else if (cnt_d != '0)   next_phase_o = PH_HOLD;
        else                    next_phase_o = PH_ACQUIRE;
    end

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= HOLD_V);

    // R4
    tick_step_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != '0 && cnt_q != $past(cnt_q)) |-> $past(tick_i));

    // R5
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_i != '0) |=> cnt_q == '0);

    // R8
    fault_clear_chk: assert property (@(posedge clk) disable iff (rst)
        fault_i |=> cnt_q == '0);

endmodule

// File: rtl/lsq_health_out.sv
module lsq_health_out
    import lock_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  qual_phase_e next_phase_i,
    output logic        unhealthy_o,
    output logic        locked_o
);
    health_flags_t flags_q;

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '{unhealthy: 1'b1, locked: 1'b0};
        else     flags_q <= flags_for(next_phase_i);
    end

    assign unhealthy_o = flags_q.unhealthy;
    assign locked_o    = flags_q.locked;

    // R1
    reset_flags_chk: assert property (@(posedge clk)
        rst |=> (flags_q.unhealthy && !flags_q.locked));

    // R4
    drop_needs_qual_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(flags_q.unhealthy) |-> $past(next_phase_i == PH_QUAL));

endmodule

// File: rtl/lock_health_seq.sv
module lock_health_seq
    import lock_seq_pkg::*;
#(
    parameter int CODE_W     = 4,
    parameter int START_CODE = 8,
    parameter int HOLD_SECS  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] phase_code_i,
    input  logic              sec_tick_i,
    input  logic              fault_i,
    output logic [CODE_W-1:0] phase_o,
    output logic              unhealthy_o,
    output logic              locked_o
);
    qual_phase_e next_phase;

    lsq_phase_reg #(
        .CODE_W     (CODE_W),
        .START_CODE (START_CODE)
    ) u_phase (
        .clk     (clk),
        .rst     (rst),
        .code_i  (phase_code_i),
        .phase_o (phase_o)
    );

    lsq_hold_timer #(
        .CODE_W    (CODE_W),
        .HOLD_SECS (HOLD_SECS)
    ) u_hold (
        .clk          (clk),
        .rst          (rst),
        .phase_i      (phase_o),
        .tick_i       (sec_tick_i),
        .fault_i      (fault_i),
        .next_phase_o (next_phase)
    );

    lsq_health_out u_out (
        .clk          (clk),
        .rst          (rst),
        .next_phase_i (next_phase),
        .unhealthy_o  (unhealthy_o),
        .locked_o     (locked_o)
    );

    // R6
    fault_fast_chk: assert property (@(posedge clk) disable iff (rst)
        fault_i |=> (unhealthy_o && !locked_o));

    // R3
    nonzero_unhealthy_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_o != '0) |=> unhealthy_o);

    // R7
    locked_zero_chk: assert property (@(posedge clk) disable iff (rst)
        locked_o |-> $past(phase_o == '0));

endmodule

// File: tb/tb_lock_health_seq.sv
module tb_lock_health_seq;

    localparam int HOLD = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] phase_code_i = 4'd8;
    logic       sec_tick_i = 1'b0;
    logic       fault_i = 1'b0;
    logic [3:0] phase_o;
    logic       unhealthy_o;
    logic       locked_o;

    int n_checks = 0;
    int n_fail = 0;

    typedef struct {
        logic [3:0] phase;
        logic       unhealthy;
        logic       locked;
        string      tag;
    } exp_t;

    exp_t sb_q[$];

    // Reference state built from the requirements
    logic [3:0] m_phase;
    int         m_secs;

    lock_health_seq dut (
        .clk          (clk),
        .rst          (rst),
        .phase_code_i (phase_code_i),
        .sec_tick_i   (sec_tick_i),
        .fault_i      (fault_i),
        .phase_o      (phase_o),
        .unhealthy_o  (unhealthy_o),
        .locked_o     (locked_o)
    );

    always #4 clk = ~clk;

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Monitor: pops expectations half a cycle after each edge
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check(e.tag, "phase_o", int'(phase_o), int'(e.phase));
            check(e.tag, "unhealthy_o", int'(unhealthy_o), int'(e.unhealthy));
            check(e.tag, "locked_o", int'(locked_o), int'(e.locked));
        end
    end

    // Driver: applies one cycle of stimulus and queues the expected result
    task automatic step(input logic [3:0] code, input logic tick, input logic flt, input string tag);
        exp_t e;
        phase_code_i = code;
        sec_tick_i   = tick;
        fault_i      = flt;
        if (m_phase != 4'd0 || flt) m_secs = 0;
        else if (tick && m_secs < HOLD) m_secs++;
        m_phase = code;
        @(posedge clk);
        #1;
        e.phase     = m_phase;
        e.unhealthy = (m_secs != HOLD);
        e.locked    = (m_secs == HOLD);
        e.tag       = tag;
        sb_q.push_back(e);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(posedge clk);
                #1;
                @(negedge clk);
                // R1 reset state
                check("R1", "phase_o", int'(phase_o), 8);
                check("R1", "unhealthy_o", int'(unhealthy_o), 1);
                check("R1", "locked_o", int'(locked_o), 0);
                @(posedge clk);
                #1;
                rst = 1'b0;
                m_phase = 4'd8;
                m_secs = 0;

                // R2 descending codes, ticks present; R3 stays unhealthy
                for (int c = 8; c >= 1; c--) step(4'(c), 1'b1, 1'b0, "R2");
                step(4'd0, 1'b1, 1'b0, "R3");
                // R4 three ticks into the hold
                for (int i = 0; i < 3; i++) step(4'd0, 1'b1, 1'b0, "R4");
                // R5 interruption then restart
                step(4'd3, 1'b0, 1'b0, "R5");
                step(4'd0, 1'b1, 1'b0, "R5");
                for (int i = 0; i < 4; i++) step(4'd0, 1'b1, 1'b0, "R5");
                step(4'd0, 1'b0, 1'b0, "R5");
                step(4'd0, 1'b1, 1'b0, "R4");
                // R7 saturation
                for (int i = 0; i < 3; i++) step(4'd0, 1'b1, 1'b0, "R7");
                step(4'd0, 1'b0, 1'b0, "R7");
                // R6 fault while qualified
                step(4'd0, 1'b0, 1'b1, "R6");
                step(4'd0, 1'b0, 1'b0, "R6");
                // R8 ticks during fault ignored
                for (int i = 0; i < 6; i++) step(4'd0, 1'b1, 1'b1, "R8");
                for (int i = 0; i < 4; i++) step(4'd0, 1'b1, 1'b0, "R8");
                step(4'd0, 1'b1, 1'b0, "R6");
                // R3 ticks with non-zero code never qualify
                step(4'd1, 1'b0, 1'b0, "R3");
                for (int i = 0; i < 6; i++) step(4'd1, 1'b1, 1'b0, "R3");
                step(4'd0, 1'b1, 1'b0, "R3");
                for (int i = 0; i < 4; i++) step(4'd0, 1'b1, 1'b0, "R4");
                step(4'd0, 1'b0, 1'b0, "R4");
                repeat (2) @(posedge clk);
                #1;
            end
            begin
                repeat (5000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule